// File: doc/BRIEF.md
# MESI Line Coherence Controller with Transient Request States

This block keeps the coherence state of every line in a small write-back cache that sits on an atomic snooping bus. Each line is Invalid, Shared, Exclusive or Modified. Processor reads and writes that hit are finished locally in the cycle they are looked up. Any other access opens one pending bus request and stalls the processor. While the request waits for the arbiter, the controller stays in a transient state (Invalid-to-Modified, Shared-to-Modified or Invalid-to-Shared/Exclusive). It keeps answering snooped transactions from other caches during that wait, so two caches that each wait on the other cannot deadlock.

For each snooped transaction the controller reports three things: whether it holds a copy, whether it holds the line dirty, and whether the dirty data must be flushed onto the bus. A release line stays high for as long as the snoop has not yet been processed. The processor and the snooper share the tag lookup. When both address the same line in the same cycle, the processor goes first and the snoop waits exactly one cycle. In the following cycle the snoop has priority. A write counts as committed, and its stall is lifted, in the cycle its exclusive-ownership command is issued. The line's data may arrive later.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: A read to a line in S, E or M, and a write to a line in E or M, finish in the cycle they are presented, with no bus request. A write to an E line leaves it in M.
- R2: A write to an S line raises bus_req. When granted, the controller issues the upgrade command (bus_cmd 3), the write finishes in that same cycle, and the line becomes M.
- R3: An invalidating snoop (bus_cmd code 2 or 3) that hits a pending Shared-to-Modified line before grant leaves the line I. On grant the controller issues read-exclusive (code 2) instead of upgrade.
- R4: A read to an I line issues read (code 1) on grant and samples bus_shared_in in the grant cycle. When fill_valid arrives, the read finishes and the line is installed in S if the sampled value was 1, or in E if it was 0.
- R5: A write to an I line issues read-exclusive (code 2) on grant and finishes in the grant cycle. The line is installed in M on fill_valid, and any processor request before that point is stalled.
- R6: For a snoop that is processed, snp_shared is asserted when the snooped command is a read (code 1) and the line is valid. snp_modified is asserted whenever the line is in M.
- R7: A processed snooped read moves an M or E line to S. A processed read-exclusive or upgrade moves a valid line to I. snp_flush is asserted when the line was M and the command was a read or a read-exclusive.
- R8: snp_release is high in every cycle that snp_valid is high but the snoop is not processed. A snoop is deferred only when the processor looks up the same line in that cycle, and it never waits more than one cycle; in that next cycle the processor access to the same line is stalled.
- R9: cpu_stall equals cpu_req with the access not finishing in that cycle. A write waiting for grant is stalled, but it is not stalled while its data is being filled.
- R10: Snoops to any line are processed while a request is waiting for grant.
- R11: After reset all lines are I, no bus request is raised, and no snoop is deferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access present; held until it finishes |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | IW | Line index of the access |
| cpu_stall | output | 1 | Access present and not finished this cycle |
| cpu_done | output | 1 | Access finishes this cycle |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant; command goes out in the same cycle |
| bus_cmd_valid | output | 1 | A command is issued this cycle |
| bus_cmd | output | 2 | 1 read, 2 read-exclusive, 3 upgrade, 0 none |
| bus_idx | output | IW | Line index of the issued command |
| bus_shared_in | input | 1 | Wired shared line from other caches, sampled at grant |
| fill_valid | input | 1 | Data for the pending read or read-exclusive has arrived |
| snp_valid | input | 1 | Snooped transaction present; held until processed |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_idx | input | IW | Line index of the snooped transaction |
| snp_release | output | 1 | Snoop not yet processed |
| snp_shared | output | 1 | This cache holds a copy of a line being read |
| snp_modified | output | 1 | This cache holds the line in M |
| snp_flush | output | 1 | Dirty data is supplied for this snoop |

## Verification
The assertions rely on the rules of an atomic bus. A snoop never coincides with this controller's own grant or with its fill data. fill_valid appears only after a read or read-exclusive has been issued. cpu_req, cpu_wr and cpu_idx stay fixed until cpu_done, and snp_valid, snp_cmd and snp_idx stay fixed until the cycle in which snp_release is low. The bench drives the arbiter and memory from its own model of the controller. It holds back grant whenever a snoop is present and holds back snoops during a fill, and it lowers each request only after the model predicts it has finished. Both the directed sequences and the random ones stay inside these rules.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_UPG = 2'd3} bus_cmd_t;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_WAIT = 2'd1, PH_FILL = 2'd2} phase_t;

  // line holds readable data
  function automatic logic holds_copy(line_st_t s);
    return s != ST_I;
  endfunction

  // line may be written without a bus transaction
  function automatic logic owns_line(line_st_t s);
    return (s == ST_E) || (s == ST_M);
  endfunction

  function automatic line_st_t after_snoop(line_st_t s, bus_cmd_t c);
    line_st_t r;
    case (c)
      CMD_RD:           r = (s == ST_I) ? ST_I : ST_S;
      CMD_RDX, CMD_UPG: r = ST_I;
      default:          r = s;
    endcase
    return r;
  endfunction

  function automatic logic must_flush(line_st_t s, bus_cmd_t c);
    return (s == ST_M) && ((c == CMD_RD) || (c == CMD_RDX));
  endfunction

  function automatic bus_cmd_t miss_cmd(logic wr, line_st_t s);
    bus_cmd_t r;
    if (!wr)            r = CMD_RD;
    else if (s == ST_S) r = CMD_UPG;
    else                r = CMD_RDX;
    return r;
  endfunction

  function automatic line_st_t fill_state(bus_cmd_t k, logic shr);
    line_st_t r;
    if (k == CMD_RD) r = shr ? ST_S : ST_E;
    else             r = ST_M;
    return r;
  endfunction

endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
  import mesi_pkg::*;
#(
  parameter int LINES = 8,
  parameter int IW    = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IW-1:0]  a_idx,
  output line_st_t       a_st,
  input  logic [IW-1:0]  b_idx,
  output line_st_t       b_st,
  input  logic           p_we,
  input  logic [IW-1:0]  p_idx,
  input  line_st_t       p_st,
  input  logic           s_we,
  input  logic [IW-1:0]  s_idx,
  input  line_st_t       s_st
);

  line_st_t st_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)                            st_q[g] <= ST_I;
      else if (s_we && (s_idx == IW'(g)))    st_q[g] <= s_st;
      else if (p_we && (p_idx == IW'(g)))    st_q[g] <= p_st;
    end
  end

  assign a_st = st_q[a_idx];
  assign b_st = st_q[b_idx];

endmodule

// File: rtl/mesi_snoop_port.sv
module mesi_snoop_port
  import mesi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     snp_valid,
  input  bus_cmd_t snp_cmd,
  input  line_st_t snp_st,
  input  logic     look_same,
  output logic     go,
  output logic     cpu_blocked,
  output logic     release_o,
  output logic     shared_o,
  output logic     modified_o,
  output logic     flush_o,
  output logic     upd_we,
  output line_st_t upd_st
);

  logic waited_q;

  always_comb begin
    // a snoop yields the tag port once, then takes it
    go          = snp_valid && (!look_same || waited_q);
    cpu_blocked = snp_valid && look_same && waited_q;
    release_o   = snp_valid && !go;
    shared_o    = go && (snp_cmd == CMD_RD) && holds_copy(snp_st);
    modified_o  = go && (snp_st == ST_M);
    flush_o     = go && must_flush(snp_st, snp_cmd);
    upd_we      = go && holds_copy(snp_st);
    upd_st      = after_snoop(snp_st, snp_cmd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) waited_q <= 1'b0;
    else        waited_q <= release_o;
  end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_wr,
  input  logic [IW-1:0] cpu_idx,
  input  line_st_t      cpu_st,
  input  logic          cpu_blocked,
  input  logic          bus_gnt,
  input  logic          bus_shared_in,
  input  logic          fill_valid,
  input  logic          snp_go,
  input  bus_cmd_t      snp_cmd,
  input  logic [IW-1:0] snp_idx,
  output logic          cpu_look,
  output logic          cpu_done,
  output logic          bus_req,
  output logic          bus_cmd_valid,
  output bus_cmd_t      bus_cmd,
  output logic [IW-1:0] bus_idx,
  output logic          p_we,
  output logic [IW-1:0] p_idx,
  output line_st_t      p_st,
  output logic          upg_kill,
  output phase_t        phase,
  output bus_cmd_t      pend_kind
);

  phase_t        ph_q, ph_d;
  bus_cmd_t      kind_q, kind_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          shr_q, shr_d;
  logic          proceed, hit, miss, grant, filled;

  always_comb begin
    cpu_look = (ph_q == PH_IDLE) && cpu_req;
    proceed  = cpu_look && !cpu_blocked;
    hit      = proceed && (cpu_wr ? owns_line(cpu_st) : holds_copy(cpu_st));
    miss     = proceed && !hit;
    grant    = (ph_q == PH_WAIT) && bus_gnt;
    filled   = (ph_q == PH_FILL) && fill_valid;
    upg_kill = (ph_q == PH_WAIT) && (kind_q == CMD_UPG) && snp_go &&
               (snp_idx == idx_q) && ((snp_cmd == CMD_RDX) || (snp_cmd == CMD_UPG));

    ph_d   = ph_q;
    kind_d = kind_q;
    idx_d  = idx_q;
    shr_d  = shr_q;
    p_we   = 1'b0;
    p_idx  = cpu_idx;
    p_st   = ST_M;

    case (ph_q)
      PH_IDLE: begin
        if (hit && cpu_wr) p_we = 1'b1;
        if (miss) begin
          ph_d   = PH_WAIT;
          kind_d = miss_cmd(cpu_wr, cpu_st);
          idx_d  = cpu_idx;
        end
      end
      PH_WAIT: begin
        if (grant) begin
          shr_d = bus_shared_in;
          if (kind_q == CMD_UPG) begin
            ph_d  = PH_IDLE;
            p_we  = 1'b1;
            p_idx = idx_q;
          end else begin
            ph_d = PH_FILL;
          end
        end else if (upg_kill) begin
          kind_d = CMD_RDX;
        end
      end
      PH_FILL: begin
        if (fill_valid) begin
          ph_d  = PH_IDLE;
          p_we  = 1'b1;
          p_idx = idx_q;
          p_st  = fill_state(kind_q, shr_q);
        end
      end
      default: ph_d = PH_IDLE;
    endcase

    cpu_done      = hit || (grant && (kind_q != CMD_RD)) || (filled && (kind_q == CMD_RD));
    bus_req       = (ph_q == PH_WAIT);
    bus_cmd_valid = grant;
    bus_cmd       = grant ? kind_q : CMD_NONE;
    bus_idx       = idx_q;
    phase         = ph_q;
    pend_kind     = kind_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      kind_q <= CMD_RD;
      idx_q  <= '0;
      shr_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      kind_q <= kind_d;
      idx_q  <= idx_d;
      shr_q  <= shr_d;
    end
  end

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter  int LINES = 8,
  localparam int IW    = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_wr,
  input  logic [IW-1:0] cpu_idx,
  output logic          cpu_stall,
  output logic          cpu_done,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_cmd_valid,
  output logic [1:0]    bus_cmd,
  output logic [IW-1:0] bus_idx,
  input  logic          bus_shared_in,
  input  logic          fill_valid,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [IW-1:0] snp_idx,
  output logic          snp_release,
  output logic          snp_shared,
  output logic          snp_modified,
  output logic          snp_flush
);

  // named internal events, also watched by the checker
  bus_cmd_t      snp_cmd_t, bus_cmd_t_w, pend_kind;
  line_st_t      cpu_st, snp_st, p_st, upd_st;
  logic          p_we, upd_we;
  logic [IW-1:0] p_idx;
  logic          cpu_look, look_same, cpu_blocked, snp_go, upg_kill, in_fill;
  phase_t        phase;

  assign snp_cmd_t = bus_cmd_t'(snp_cmd);
  assign look_same = cpu_look && (cpu_idx == snp_idx);
  assign in_fill   = (phase == PH_FILL);
  assign cpu_stall = cpu_req && !cpu_done;
  assign bus_cmd   = bus_cmd_t_w;

  mesi_line_array #(.LINES(LINES), .IW(IW)) u_lines (
    .clk   (clk),
    .rst_n (rst_n),
    .a_idx (cpu_idx),
    .a_st  (cpu_st),
    .b_idx (snp_idx),
    .b_st  (snp_st),
    .p_we  (p_we),
    .p_idx (p_idx),
    .p_st  (p_st),
    .s_we  (upd_we),
    .s_idx (snp_idx),
    .s_st  (upd_st)
  );

  mesi_snoop_port u_snoop (
    .clk         (clk),
    .rst_n       (rst_n),
    .snp_valid   (snp_valid),
    .snp_cmd     (snp_cmd_t),
    .snp_st      (snp_st),
    .look_same   (look_same),
    .go          (snp_go),
    .cpu_blocked (cpu_blocked),
    .release_o   (snp_release),
    .shared_o    (snp_shared),
    .modified_o  (snp_modified),
    .flush_o     (snp_flush),
    .upd_we      (upd_we),
    .upd_st      (upd_st)
  );

  mesi_req_fsm #(.IW(IW)) u_req (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req       (cpu_req),
    .cpu_wr        (cpu_wr),
    .cpu_idx       (cpu_idx),
    .cpu_st        (cpu_st),
    .cpu_blocked   (cpu_blocked),
    .bus_gnt       (bus_gnt),
    .bus_shared_in (bus_shared_in),
    .fill_valid    (fill_valid),
    .snp_go        (snp_go),
    .snp_cmd       (snp_cmd_t),
    .snp_idx       (snp_idx),
    .cpu_look      (cpu_look),
    .cpu_done      (cpu_done),
    .bus_req       (bus_req),
    .bus_cmd_valid (bus_cmd_valid),
    .bus_cmd       (bus_cmd_t_w),
    .bus_idx       (bus_idx),
    .p_we          (p_we),
    .p_idx         (p_idx),
    .p_st          (p_st),
    .upg_kill      (upg_kill),
    .phase         (phase),
    .pend_kind     (pend_kind)
  );

endmodule

// File: rtl/mesi_snoop_chk.sv
module mesi_snoop_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req,
  input logic       cpu_stall,
  input logic       cpu_done,
  input logic       bus_req,
  input logic       bus_cmd_valid,
  input logic [1:0] bus_cmd,
  input logic       fill_valid,
  input logic       snp_valid,
  input logic [1:0] snp_cmd,
  input logic       snp_release,
  input logic       snp_shared,
  input logic       snp_modified,
  input logic       snp_flush,
  input logic       upg_kill,
  input logic       in_fill,
  input logic [1:0] pend_kind
);

  // R8: a held snoop is deferred for one cycle at most
  a_r8_release_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_release) |=> !snp_release);

  // R7: flushed data always comes from a modified line
  a_r7_flush_needs_modified: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_modified);

  // R6: a dirty holder of a line being read also reports a copy
  a_r6_dirty_read_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_modified && (snp_cmd == 2'd1)) |-> snp_shared);

  // R2: the request is withdrawn after the command goes out
  a_r2_req_drops_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |=> !bus_req);

  // R3: a killed upgrade turns into a pending read-exclusive
  a_r3_kill_becomes_rdx: assert property (@(posedge clk) disable iff (!rst_n)
    upg_kill |=> (bus_req && (pend_kind == 2'd2)));

  // R9: an exclusive command is the commit point of the write
  a_r9_commit_releases_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_valid && (bus_cmd != 2'd1)) |-> cpu_done);

  // R5: nothing new proceeds until the fill lands
  a_r5_fill_blocks_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fill && cpu_req && !fill_valid) |-> cpu_stall);

  // R11: reset leaves no request and no fill pending
  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!bus_req && !in_fill));

endmodule

bind mesi_snoop_ctrl mesi_snoop_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req       (cpu_req),
  .cpu_stall     (cpu_stall),
  .cpu_done      (cpu_done),
  .bus_req       (bus_req),
  .bus_cmd_valid (bus_cmd_valid),
  .bus_cmd       (bus_cmd),
  .fill_valid    (fill_valid),
  .snp_valid     (snp_valid),
  .snp_cmd       (snp_cmd),
  .snp_release   (snp_release),
  .snp_shared    (snp_shared),
  .snp_modified  (snp_modified),
  .snp_flush     (snp_flush),
  .upg_kill      (upg_kill),
  .in_fill       (in_fill),
  .pend_kind     (pend_kind)
);

// File: tb/sim_mesi_snoop_ctrl.sv
module sim_mesi_snoop_ctrl;

  localparam int LINES = 8;
  localparam int IW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_wr = 1'b0;
  logic [IW-1:0] cpu_idx = '0;
  logic cpu_stall, cpu_done, bus_req, bus_cmd_valid;
  logic bus_gnt = 1'b0, bus_shared_in = 1'b0, fill_valid = 1'b0;
  logic [1:0] bus_cmd;
  logic [IW-1:0] bus_idx;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'd0;
  logic [IW-1:0] snp_idx = '0;
  logic snp_release, snp_shared, snp_modified, snp_flush;

  always #5 clk = ~clk;

  mesi_snoop_ctrl #(.LINES(LINES)) u0 (.*);

  // reference model: states I0 S1 E2 M3, commands RD1 RDX2 UPG3, phases idle0 wait1 fill2
  int mst [LINES];
  int ph, kind, pidx, wcnt, fcnt;
  bit fsh, waited;
  bit cpu_pend, cpu_wr_p, snp_pend;
  int cpu_idx_p, snp_cmd_p, snp_idx_p;
  int gnt_lat = 1, fill_lat = 1;
  bit shr_in;
  string cur_tag = "R11";
  int n_run = 0, n_fail = 0;
  int last_cmd, rel_cycles, stall_cycles;
  bit seen_flush, seen_mod, seen_shr;
  bit finished = 1'b0;

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (mst[i]) mst[i] = 0;
    ph = 0; kind = 1; pidx = 0; wcnt = 0; fcnt = 0; fsh = 0; waited = 0;
    cpu_pend = 0; snp_pend = 0;
  endtask

  task automatic step();
    bit lk, sgo, cblk, e_done, e_rel, e_shr, e_mod, e_fl, gnt;
    int sst, cst, nph, e_cmd;
    cpu_req       = cpu_pend;
    cpu_wr        = cpu_wr_p;
    cpu_idx       = IW'(cpu_idx_p);
    snp_valid     = snp_pend && (ph != 2);
    snp_cmd       = 2'(snp_cmd_p);
    snp_idx       = IW'(snp_idx_p);
    gnt           = (ph == 1) && (wcnt >= gnt_lat) && !snp_valid;
    bus_gnt       = gnt;
    fill_valid    = (ph == 2) && (fcnt >= fill_lat);
    bus_shared_in = shr_in;
    #2;
    // snoop side
    lk   = (ph == 0) && cpu_pend && (cpu_idx_p == snp_idx_p);
    sgo  = snp_valid && (!lk || waited);
    cblk = lk && snp_valid && waited;
    e_rel = snp_valid && !sgo;
    sst  = mst[snp_idx_p];
    e_shr = sgo && (snp_cmd_p == 1) && (sst != 0);
    e_mod = sgo && (sst == 3);
    e_fl  = e_mod && (snp_cmd_p != 3);
    // processor side
    e_done = 0; e_cmd = 0; nph = ph;
    if (ph == 0) begin
      if (cpu_pend && !cblk) begin
        cst = mst[cpu_idx_p];
        if (!cpu_wr_p && cst != 0) e_done = 1;
        else if (cpu_wr_p && cst >= 2) begin e_done = 1; mst[cpu_idx_p] = 3; end
        else begin
          nph = 1; pidx = cpu_idx_p;
          kind = !cpu_wr_p ? 1 : (cst == 1 ? 3 : 2);
        end
      end
    end else if (ph == 1) begin
      if (gnt) begin
        e_cmd = kind;
        fsh = shr_in;
        if (kind != 1) e_done = 1;
        if (kind == 3) begin mst[pidx] = 3; nph = 0; end
        else nph = 2;
      end else if (sgo && snp_idx_p == pidx && kind == 3 && snp_cmd_p != 1) kind = 2;
    end else if (fill_valid) begin
      mst[pidx] = (kind == 1) ? (fsh ? 1 : 2) : 3;
      if (kind == 1) e_done = 1;
      nph = 0;
    end
    if (sgo && sst != 0) mst[snp_idx_p] = (snp_cmd_p == 1) ? 1 : 0;
    // compare
    chk(cur_tag, "cpu_done", cpu_done, e_done);
    chk(cur_tag, "cpu_stall", cpu_stall, cpu_pend && !e_done);
    chk(cur_tag, "bus_req", bus_req, ph == 1);
    chk(cur_tag, "bus_cmd_valid", bus_cmd_valid, gnt);
    chk(cur_tag, "bus_cmd", bus_cmd, e_cmd);
    if (gnt) chk(cur_tag, "bus_idx", bus_idx, pidx);
    chk(cur_tag, "snp_release", snp_release, e_rel);
    chk(cur_tag, "snp_shared", snp_shared, e_shr);
    chk(cur_tag, "snp_modified", snp_modified, e_mod);
    chk(cur_tag, "snp_flush", snp_flush, e_fl);
    // observations from the ports
    if (bus_cmd_valid) last_cmd = bus_cmd;
    rel_cycles   += snp_release;
    stall_cycles += cpu_stall;
    seen_flush |= snp_flush; seen_mod |= snp_modified; seen_shr |= snp_shared;
    // advance
    waited = e_rel;
    wcnt = (ph == 1 && nph == 1) ? wcnt + 1 : 0;
    fcnt = (ph == 2 && nph == 2) ? fcnt + 1 : 0;
    ph = nph;
    if (e_done) cpu_pend = 0;
    if (sgo) snp_pend = 0;
    @(negedge clk); #1;
  endtask

  task automatic post_cpu(bit wr, int idx);
    cpu_pend = 1; cpu_wr_p = wr; cpu_idx_p = idx;
  endtask

  task automatic post_snp(int cmd, int idx);
    snp_pend = 1; snp_cmd_p = cmd; snp_idx_p = idx;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic settle();
    for (int k = 0; k < 60; k++) begin
      if (!cpu_pend && !snp_pend && ph == 0) break;
      step();
    end
  endtask

  task automatic clear_seen();
    seen_flush = 0; seen_mod = 0; seen_shr = 0; last_cmd = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: quiet after reset
    chk("R11", "bus_req", bus_req, 0);
    chk("R11", "cpu_stall", cpu_stall, 0);
    chk("R11", "snp_release", snp_release, 0);
    run(2);

    // R4: read miss, no sharers -> E
    cur_tag = "R4"; clear_seen(); shr_in = 0;
    post_cpu(0, 1); settle();
    chk("R4", "issued cmd", last_cmd, 1);

    // R1: read hit and silent E->M write
    cur_tag = "R1"; clear_seen();
    post_cpu(0, 1); settle();
    post_cpu(1, 1); settle();
    chk("R1", "no bus cmd on hits", last_cmd, 0);

    // R6/R7: snooped read of the M line
    cur_tag = "R7"; clear_seen();
    post_snp(1, 1); settle();
    chk("R7", "flush on read of M", seen_flush, 1);
    chk("R6", "modified reported", seen_mod, 1);
    chk("R6", "shared reported", seen_shr, 1);

    // R2: write to S line -> upgrade
    cur_tag = "R2"; clear_seen(); gnt_lat = 3;
    post_cpu(1, 1); settle();
    chk("R2", "upgrade issued", last_cmd, 3);

    // R7: read-exclusive snoop of M line -> flush, I
    cur_tag = "R7"; clear_seen();
    post_snp(2, 1); settle();
    chk("R7", "flush on rdx of M", seen_flush, 1);
    post_cpu(0, 1); settle();
    chk("R7", "line invalid after rdx", last_cmd, 1);

    // R4: read miss with sharers -> S
    cur_tag = "R4"; clear_seen(); shr_in = 1;
    post_cpu(0, 2); settle(); shr_in = 0;
    clear_seen();
    post_snp(1, 2); settle();
    chk("R4", "installed shared", seen_shr, 1);
    chk("R6", "clean line not modified", seen_mod, 0);

    // R3: upgrade killed before grant -> read-exclusive
    cur_tag = "R3"; clear_seen(); gnt_lat = 6;
    post_cpu(1, 2); run(2);
    post_snp(3, 2); settle();
    chk("R3", "converted cmd", last_cmd, 2);

    // R10: snoop serviced while waiting for grant
    cur_tag = "R10"; clear_seen();
    post_cpu(1, 5); run(2);
    post_snp(1, 1); run(2);
    chk("R10", "snoop answered while waiting", seen_shr, 1);
    settle();

    // R5: write miss, later access stalls during fill
    cur_tag = "R5"; clear_seen(); gnt_lat = 1; fill_lat = 4;
    post_cpu(1, 3);
    for (int k = 0; k < 20 && cpu_pend; k++) step();
    post_cpu(0, 3); stall_cycles = 0; settle();
    chk("R5", "rdx issued", last_cmd, 2);
    chk("R5", "stalled through fill", stall_cycles > 0, 1);

    // R8: same-line lookup defers the snoop once, then blocks the cpu
    cur_tag = "R8"; clear_seen(); rel_cycles = 0;
    post_cpu(0, 3); post_snp(1, 3); run(1);
    post_cpu(0, 3); settle();
    chk("R8", "release cycles", rel_cycles, 1);
    chk("R8", "flush after deferral", seen_flush, 1);

    // R9: write stalls only until grant, not through fill
    cur_tag = "R9"; gnt_lat = 5; fill_lat = 5; stall_cycles = 0;
    post_cpu(1, 6); settle();
    chk("R9", "write stall cycles", stall_cycles, 6);

    // R10: random traffic with snoops during waits
    cur_tag = "R10";
    for (int k = 0; k < 4000; k++) begin
      if (!cpu_pend && $urandom_range(0, 2) == 0) post_cpu($urandom_range(0, 1), $urandom_range(0, LINES - 1));
      if (!snp_pend && $urandom_range(0, 3) == 0) post_snp($urandom_range(1, 3), $urandom_range(0, LINES - 1));
      if (ph == 0) begin gnt_lat = $urandom_range(0, 4); fill_lat = $urandom_range(0, 3); end
      shr_in = $urandom_range(0, 1);
      step();
    end
    settle();

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule